// File: doc/BRIEF.md
# Arithmetic Status Flags Unit

This block sits beside an integer datapath and keeps its condition word. After each add, subtract, logical or shift/rotate step, the datapath presents both operands, the result, a one-bit carry (the carry or borrow out of the top bit for add and subtract, or the last bit shifted out for a shift or rotate), the operand size and the operation class. When the update strobe is high, the unit works out zero, sign, signed overflow, nibble carry, parity and carry for that size and stores them. A separate strobe loads three control bits: string direction, interrupt enable and single-step trap.

All of these bits are packed into one 16-bit word at fixed positions. Spare positions read as constants. Other logic decodes the word directly. The block does not sequence anything itself. The status and control bits are two groups of registers with their own write strobes. Both groups may be written in the same cycle.

Top module: `arith_flags_unit`

## Requirements
- R1: Zero (bit 6) is 1 after an update exactly when the result, truncated to the operand size, is all zeros. Result bits above the size have no effect. Size codes: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit.
- R2: Sign (bit 7) takes bit 7, 15 or 31 of the result, chosen by the operand size.
- R3: Carry (bit 0) takes the carry input for the classes add (code 0), subtract (code 1) and shift/rotate (code 3). It is cleared for the logical class (code 2), whatever the carry input is.
- R4: Overflow (bit 11) is set for add when both operands have the same sign and the result has the other sign. It is set for subtract (a minus b) when the operand signs differ and the result sign differs from a. It is cleared for logical operations and kept unchanged for shifts.
- R5: Nibble carry (bit 4) is operand a bit 4 XOR operand b bit 4 XOR result bit 4 for add and subtract. It is kept unchanged for logical and shift operations.
- R6: Parity (bit 2) is 1 when the low byte of the result has an even number of ones, for every size.
- R7: When the control strobe is high, direction (bit 10), interrupt enable (bit 9) and trap (bit 8) load from their inputs on the clock edge. The status bits are not affected. An update in the same cycle also takes effect.
- R8: Bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.
- R9: With both strobes low, the whole word holds its value. With only the update strobe high, the control bits hold.
- R10: Reset (active low, asynchronous) sets the word to 16'h0002.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Store status flags from this cycle's operation |
| op_class | input | 2 | 0 add, 1 subtract, 2 logical, 3 shift/rotate |
| op_size | input | 2 | 0 byte, 1 word, 2/3 doubleword |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | input | 32 | Datapath result |
| carry_in | input | 1 | Carry/borrow out, or last bit shifted out |
| ctl_we | input | 1 | Load the control bits |
| ctl_dir | input | 1 | Direction value: 0 ascending, 1 descending |
| ctl_ien | input | 1 | Interrupt enable value |
| ctl_trap | input | 1 | Single-step trap value |
| flags_out | output | 16 | Packed flags word |

## Verification
The hardest cases to reach are the bits that keep their old value: overflow across a shift, and nibble carry across logical and shift steps. A wrong "keep" only shows when the earlier value differs from what a fresh computation would give. To get there, the stimulus table first sets overflow and nibble carry with an add, then runs logical and shift steps, and reads those bits after each one. Size masking is exercised with results whose upper bits are nonzero while the bits inside the operand size are zero.

// File: rtl/flg_pkg.sv
package flg_pkg;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_LOGIC = 2'd2,
        CLS_SHIFT = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } op_size_e;

    typedef struct packed {
        logic of;
        logic sf;
        logic zf;
        logic af;
        logic pf;
        logic cf;
    } status_t;

    localparam int POS_CF = 0;
    localparam int POS_ONE = 1;
    localparam int POS_PF = 2;
    localparam int POS_AF = 4;
    localparam int POS_ZF = 6;
    localparam int POS_SF = 7;
    localparam int POS_TF = 8;
    localparam int POS_IF = 9;
    localparam int POS_DF = 10;
    localparam int POS_OF = 11;

endpackage

// File: rtl/flg_parity.sv
module flg_parity #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bits_in,
    output logic             even_out
);
    logic [WIDTH:0] chain;
    assign chain[0] = 1'b1;
    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ bits_in[i];
    end
    assign even_out = chain[WIDTH];
endmodule

// File: rtl/flg_status_calc.sv
module flg_status_calc
    import flg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 8
) (
    input  op_class_e        cls,
    input  op_size_e         size,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] r,
    input  logic              cin,
    input  logic              of_held,
    input  logic              af_held,
    output status_t           nxt
);
    localparam int MSB8  = 7;
    localparam int MSB16 = 15;
    localparam int MSB32 = DATA_W - 1;

    logic [DATA_W-1:0] mask;
    logic sa, sb, sr;
    logic even;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                mask = {{(DATA_W-8){1'b0}}, 8'hFF};
                sa = a[MSB8];  sb = b[MSB8];  sr = r[MSB8];
            end
            SZ_WORD: begin
                mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
                sa = a[MSB16]; sb = b[MSB16]; sr = r[MSB16];
            end
            default: begin
                mask = '1;
                sa = a[MSB32]; sb = b[MSB32]; sr = r[MSB32];
            end
        endcase
    end

    flg_parity #(.WIDTH(PAR_W)) u_par (
        .bits_in (r[PAR_W-1:0]),
        .even_out(even)
    );

    always_comb begin
        nxt.zf = ((r & mask) == '0);
        nxt.sf = sr;
        nxt.pf = even;
        unique case (cls)
            CLS_ADD: begin
                nxt.cf = cin;
                nxt.of = (sa == sb) && (sr != sa);
                nxt.af = a[4] ^ b[4] ^ r[4];
            end
            CLS_SUB: begin
                nxt.cf = cin;
                nxt.of = (sa != sb) && (sr != sa);
                nxt.af = a[4] ^ b[4] ^ r[4];
            end
            CLS_LOGIC: begin
                nxt.cf = 1'b0;
                nxt.of = 1'b0;
                nxt.af = af_held;
            end
            default: begin
                nxt.cf = cin;
                nxt.of = of_held;
                nxt.af = af_held;
            end
        endcase
    end

    // R6: parity output agrees with the low-byte population count
    always_comb begin
        a_r6_parity_even: assert (even == ($countones(r[PAR_W-1:0]) % 2 == 0))
            else $error("R6 parity mismatch");
    end
endmodule

// File: rtl/arith_flags_unit.sv
module arith_flags_unit
    import flg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FLAG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_class,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    input  logic              carry_in,
    input  logic              ctl_we,
    input  logic              ctl_dir,
    input  logic              ctl_ien,
    input  logic              ctl_trap,
    output logic [FLAG_W-1:0] flags_out
);
    status_t st_q, st_d;
    logic dir_q, ien_q, trap_q;

    flg_status_calc #(.DATA_W(DATA_W), .PAR_W(8)) u_calc (
        .cls    (op_class_e'(op_class)),
        .size   (op_size_e'(op_size)),
        .a      (opnd_a),
        .b      (opnd_b),
        .r      (result),
        .cin    (carry_in),
        .of_held(st_q.of),
        .af_held(st_q.af),
        .nxt    (st_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (upd_en) begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            ien_q  <= 1'b0;
            trap_q <= 1'b0;
        end else if (ctl_we) begin
            dir_q  <= ctl_dir;
            ien_q  <= ctl_ien;
            trap_q <= ctl_trap;
        end
    end

    always_comb begin
        flags_out          = '0;
        flags_out[POS_ONE] = 1'b1;
        flags_out[POS_CF]  = st_q.cf;
        flags_out[POS_PF]  = st_q.pf;
        flags_out[POS_AF]  = st_q.af;
        flags_out[POS_ZF]  = st_q.zf;
        flags_out[POS_SF]  = st_q.sf;
        flags_out[POS_TF]  = trap_q;
        flags_out[POS_IF]  = ien_q;
        flags_out[POS_DF]  = dir_q;
        flags_out[POS_OF]  = st_q.of;
    end

    a_r9_hold_all: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en && !ctl_we) |=> $stable(flags_out));

    a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[1] && flags_out[3] == 1'b0 && flags_out[5] == 1'b0 &&
        flags_out[FLAG_W-1:12] == '0);

    a_r7_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (flags_out[10] == $past(ctl_dir) && flags_out[9] == $past(ctl_ien) &&
                    flags_out[8] == $past(ctl_trap)));

    a_r3_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'd2) |=> (!flags_out[0] && !flags_out[11]));

    a_r5_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class[1]) |=> $stable(flags_out[4]));

    a_r4_of_shift_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_class == 2'd3) |=> $stable(flags_out[11]));
endmodule

// File: tb/arith_flags_unit_test.sv
module arith_flags_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, result = '0;
    logic        carry_in = 1'b0;
    logic        ctl_we = 1'b0, ctl_dir = 1'b0, ctl_ien = 1'b0, ctl_trap = 1'b0;
    logic [15:0] flags_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    arith_flags_unit uut (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
        .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_in(carry_in), .ctl_we(ctl_we), .ctl_dir(ctl_dir),
        .ctl_ien(ctl_ien), .ctl_trap(ctl_trap), .flags_out(flags_out)
    );

    // {class, size, a, b, r, carry, upd, expected}
    localparam int NV = 10;
    localparam logic [117:0] VEC [NV] = '{
        {2'd0, 2'd0, 32'h0000007F, 32'h00000001, 32'h00000080, 1'b0, 1'b1, 16'h0892}, // R4 R5 R2 add ovf
        {2'd0, 2'd0, 32'h000000FF, 32'h00000001, 32'hABCD1200, 1'b1, 1'b1, 16'h0057}, // R1 masked zero, R3 carry
        {2'd1, 2'd1, 32'h00008000, 32'h00000001, 32'h00007FFF, 1'b0, 1'b1, 16'h0816}, // R4 sub ovf, R6
        {2'd2, 2'd2, 32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 1'b0, 1'b1, 16'h0056}, // R3 R4 clear, R5 keep
        {2'd3, 2'd2, 32'h40000001, 32'h00000001, 32'h80000003, 1'b1, 1'b1, 16'h0097}, // R4 R5 keep on shift
        {2'd0, 2'd0, 32'h00000000, 32'h00000000, 32'h00000000, 1'b1, 1'b0, 16'h0097}, // R9 hold
        {2'd1, 2'd2, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0, 1'b1, 16'h0046}, // R1 dword zero
        {2'd1, 2'd0, 32'h00000000, 32'h00000001, 32'h000000FF, 1'b1, 1'b1, 16'h0097}, // R3 borrow, R6
        {2'd0, 2'd1, 32'h00000100, 32'h00000000, 32'h00010000, 1'b0, 1'b1, 16'h0046}, // R1 word mask
        {2'd2, 2'd0, 32'h00000007, 32'h00000007, 32'h00000007, 1'b1, 1'b1, 16'h0002}  // R3 logic CF clear, R6 odd
    };

    task automatic check(input string tag, input logic [15:0] exp);
        total++;
        if (flags_out !== exp) begin
            bad++;
            $display("FAIL %s: flags_out=%h expected=%h", tag, flags_out, exp);
        end
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: expired expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R10 reset value", 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", 16'h0002);

        for (int i = 0; i < NV; i++) begin
            {op_class, op_size, opnd_a, opnd_b, result, carry_in, upd_en} = VEC[i][117:16];
            @(negedge clk);
            upd_en = 1'b0;
            check($sformatf("R1-vector %0d", i), VEC[i][15:0]);
        end

        // R7: control load alone leaves status bits
        ctl_we = 1'b1; ctl_dir = 1'b1; ctl_ien = 1'b0; ctl_trap = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        check("R7 control load", 16'h0502);

        // R7: control and status in same cycle
        ctl_we = 1'b1; ctl_dir = 1'b0; ctl_ien = 1'b1; ctl_trap = 1'b0;
        upd_en = 1'b1; op_class = 2'd0; op_size = 2'd0;
        opnd_a = 32'h0; opnd_b = 32'h0; result = 32'h0; carry_in = 1'b0;
        @(negedge clk);
        ctl_we = 1'b0; upd_en = 1'b0;
        check("R7 joint write", 16'h0246);

        // R9: update only, control bits hold; R2 sign of dword
        ctl_dir = 1'b1; ctl_trap = 1'b1; ctl_ien = 1'b0;
        upd_en = 1'b1; op_class = 2'd3; op_size = 2'd3;
        result = 32'h80000000; carry_in = 1'b0;
        @(negedge clk);
        upd_en = 1'b0;
        check("R9 control held R2", 16'h0286);

        // R8 via both strobes idle, then R9 hold
        @(negedge clk);
        check("R9 idle hold", 16'h0286);
        if (flags_out[1] !== 1'b1 || flags_out[15:12] !== 4'h0) begin
            total++; bad++;
            $display("FAIL R8 fixed bits: flags_out=%h expected bit1=1 top=0", flags_out);
        end else total++;

        // R10 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid-run reset", 16'h0002);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule